// File: doc/BRIEF.md
# Display MMU Translation Prefetcher

This block sits next to one display layer's fetch engine. It sends address-translation warm-up requests to a system MMU, so that translations are already cached when the layer reads its framebuffer. Software programs a 32-bit control word, and a base address and a byte size for each of up to three planes of the layer. The fetch engine reports each read address it issues. The block sends page-aligned request addresses out on a valid/ready handshake.

There are two strategies. Partial mode uses small pages (4 KiB or 64 KiB). It keeps a programmable number of pages requested ahead of the reader, and follows the reader as it advances. Full mode uses large pages (1 MiB or 2 MiB). It requests every page of every plane in plane order, then raises a done flag. A frame-start pulse captures the whole configuration and restarts all progress. The request side therefore always works on one consistent setup for the whole frame.

Top module: `mmu_prefetcher`

## Requirements
- R1: When control bit 0 was clear at the last frame start, `req_valid` stays low for the whole frame and `full_done` stays low.
- R2: With bit 0 set, control bit 4 set selects partial mode and bit 4 clear selects full mode.
- R3: Control bits 18:12 give the partial-mode depth D (0 to 127). Before the reader touches plane p, exactly min(D, pages of p) pages of that plane are requested, starting at its first page. D = 0 requests nothing ahead.
- R4: Control bit 8+p selects the page size of plane p. The size is 64 KiB if the bit is set and 4 KiB if it is clear in partial mode, and 2 MiB if set and 1 MiB if clear in full mode.
- R5: In partial mode, once the reader has read page k of a plane, the block requests that plane's pages up to index k+D. Page index 0 is the page holding the plane's base address.
- R6: In full mode every page that overlaps [base, base+size) of every plane with a non-zero size is requested. The order is plane 0, then plane 1, then plane 2, with ascending addresses inside each plane.
- R7: Every request address is a multiple of the plane's page size, and no page is requested twice in a frame.
- R8: A frame-start pulse captures the configuration, drops any pending request and restarts every plane from page 0. `req_valid` is low in the cycle after the pulse.
- R9: In full mode `full_done` goes high once the last page has been accepted. It is low before that, and it is never high in partial mode or when the block is off.
- R10: Partial mode never requests a page past the last page of a plane's buffer, even when the reader is near the end.
- R11: While `req_valid` is high and `req_ready` is low, `req_valid` stays high and `req_addr` holds its value.
- R12: After reset, `req_valid` and `full_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse that captures the configuration and restarts progress |
| ctrl_word | input | 32 | Control word: enable, mode, per-plane page size, depth |
| plane_base | input | NPL*AW | Byte base address per plane, plane p in bits [p*AW +: AW] |
| plane_size | input | NPL*AW | Byte size per plane; zero means the plane is unused |
| read_valid | input | 1 | The reader issued a read this cycle |
| read_addr | input | AW | Byte address of that read |
| req_valid | output | 1 | A prefetch request is offered |
| req_ready | input | 1 | The MMU accepts the offered request |
| req_addr | output | AW | Page-aligned address of the offered request |
| full_done | output | 1 | Full mode has had every page accepted |

## Verification
The bench sweeps all eight page-size patterns in full mode, with a base that is not aligned to a page. A design that counted pages from the byte size alone would miss the trailing page or request an extra one. Partial mode is swept over depths 0, 1, 2, 5 and 127 across every page-size pattern. This catches an off-by-one in the readahead window and a depth field read from the wrong bits. A reader that jumps to the last page of a plane shows whether the block stops at the end of the buffer. Stalls on `req_ready`, and a restart issued while a request is still pending, show whether a design loses a request, sends one twice, or carries state over into the next frame.

// File: rtl/mmu_pf_pkg.sv
// Shared definitions for the display MMU prefetcher.
// Assumes: at most four planes, because the page-size select bits sit
// between bit 8 and the depth field at bit 12.
package mmu_pf_pkg;

    typedef enum logic [1:0] {
        PF_OFF     = 2'd0,
        PF_PARTIAL = 2'd1,
        PF_FULL    = 2'd2
    } pf_mode_e;

    localparam int CTL_EN_BIT      = 0;
    localparam int CTL_PARTIAL_BIT = 4;
    localparam int CTL_BIG_LSB     = 8;
    localparam int CTL_DEPTH_LSB   = 12;
    localparam int DEPTH_W         = 7;
    localparam int SHIFT_W         = 5;

    // log2 of the page size for a mode and a page-size select bit
    function automatic logic [SHIFT_W-1:0] page_shift(pf_mode_e m, logic big);
        if (m == PF_PARTIAL) return big ? SHIFT_W'(16) : SHIFT_W'(12);
        else                 return big ? SHIFT_W'(21) : SHIFT_W'(20);
    endfunction

endpackage

// File: rtl/mmu_pf_cfg.sv
// Configuration capture. On frame_start it decodes the control word into
// the mode, the depth and one page shift per plane, and it holds the plane
// base and size until the next frame_start.
// Assumes: NPL <= 4.
module mmu_pf_cfg
    import mmu_pf_pkg::*;
#(
    parameter int AW  = 32,
    parameter int NPL = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          frame_start,
    input  logic [31:0]                   ctrl_word,
    input  logic [NPL*AW-1:0]             base_flat,
    input  logic [NPL*AW-1:0]             size_flat,
    output pf_mode_e                      mode,
    output logic [DEPTH_W-1:0]            depth,
    output logic [NPL-1:0][SHIFT_W-1:0]   shift,
    output logic [NPL-1:0][AW-1:0]        base,
    output logic [NPL-1:0][AW-1:0]        size
);

    pf_mode_e mode_dec;

    // decode the requested mode from the enable and mode bits
    always_comb begin
        if (!ctrl_word[CTL_EN_BIT])          mode_dec = PF_OFF;
        else if (ctrl_word[CTL_PARTIAL_BIT]) mode_dec = PF_PARTIAL;
        else                                 mode_dec = PF_FULL;
    end

    // capture mode and depth at frame start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode  <= PF_OFF;
            depth <= '0;
        end else if (frame_start) begin
            mode  <= mode_dec;
            depth <= ctrl_word[CTL_DEPTH_LSB +: DEPTH_W];
        end
    end

    for (genvar p = 0; p < NPL; p++) begin : g_plane
        // capture the descriptor and page shift of plane p at frame start
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                shift[p] <= '0;
                base[p]  <= '0;
                size[p]  <= '0;
            end else if (frame_start) begin
                shift[p] <= page_shift(mode_dec, ctrl_word[CTL_BIG_LSB + p]);
                base[p]  <= base_flat[p*AW +: AW];
                size[p]  <= size_flat[p*AW +: AW];
            end
        end
    end

endmodule

// File: rtl/mmu_pf_plane.sv
// Progress tracker for one plane. It works out the page range that the
// plane's buffer covers, keeps a cursor to the next page to request, and
// records the highest page the reader has touched. It asks for a slot
// while the cursor is below both the page count and the mode's limit.
// Assumes: base + size does not wrap the address space.
module mmu_pf_plane
    import mmu_pf_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_start,
    input  pf_mode_e           mode,
    input  logic [DEPTH_W-1:0] depth,
    input  logic [SHIFT_W-1:0] shift,
    input  logic [AW-1:0]      base,
    input  logic [AW-1:0]      size,
    input  logic               read_valid,
    input  logic [AW-1:0]      read_addr,
    input  logic               take,
    output logic               want,
    output logic [AW-1:0]      page_addr
);

    localparam int CW = AW + 1;

    logic [AW-1:0] first_pg, last_pg, cursor, rmax, rpage;
    logic [CW-1:0] npages, limit, cur_w;
    logic          seen, hit;

    // page range covered by the buffer
    always_comb begin
        first_pg = base >> shift;
        last_pg  = (base + size - AW'(1)) >> shift;
        npages   = (size == '0) ? '0 : ({1'b0, last_pg - first_pg} + CW'(1));
    end

    // does the current read fall inside this plane, and on which page
    always_comb begin
        hit   = read_valid && (read_addr >= base) && ((read_addr - base) < size);
        rpage = (read_addr >> shift) - first_pg;
    end

    // request limit for the mode, and whether a request is due
    always_comb begin
        cur_w = {1'b0, cursor};
        case (mode)
            PF_FULL:    limit = npages;
            PF_PARTIAL: limit = seen ? ({1'b0, rmax} + CW'(depth) + CW'(1))
                                     : CW'(depth);
            default:    limit = '0;
        endcase
        want      = (cur_w < npages) && (cur_w < limit);
        page_addr = (first_pg + cursor) << shift;
    end

    // advance the cursor on a grant and follow the reader's highest page
    always_ff @(posedge clk) begin
        if (!rst_n || frame_start) begin
            cursor <= '0;
            rmax   <= '0;
            seen   <= 1'b0;
        end else begin
            if (take) cursor <= cursor + AW'(1);
            if (hit && (!seen || rpage > rmax)) begin
                rmax <= rpage;
                seen <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/mmu_pf_pick.sv
// Fixed-priority selector. It grants the lowest-numbered plane that wants
// a slot. In full mode this gives plane-by-plane order.
module mmu_pf_pick #(
    parameter int N = 3
) (
    input  logic [N-1:0] want,
    output logic [N-1:0] gnt,
    output logic         any
);

    // isolate the lowest set bit
    always_comb begin
        gnt = want & (~want + N'(1));
        any = |want;
    end

endmodule

// File: rtl/mmu_prefetcher.sv
// Display MMU translation prefetcher, top level. It captures the
// configuration at frame start, runs one tracker per plane, picks one
// plane per cycle and holds the chosen page in an output register that
// stays stable until the MMU accepts it.
// Assumes: read addresses come from the layer that this block serves.
module mmu_prefetcher
    import mmu_pf_pkg::*;
#(
    parameter int AW  = 32,
    parameter int NPL = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic [31:0]       ctrl_word,
    input  logic [NPL*AW-1:0] plane_base,
    input  logic [NPL*AW-1:0] plane_size,
    input  logic              read_valid,
    input  logic [AW-1:0]     read_addr,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [AW-1:0]     req_addr,
    output logic              full_done
);

    pf_mode_e                    cfg_mode;
    logic [DEPTH_W-1:0]          cfg_depth;
    logic [NPL-1:0][SHIFT_W-1:0] cfg_shift;
    logic [NPL-1:0][AW-1:0]      cfg_base, cfg_size, pg_addr;
    logic [NPL-1:0]              want, gnt, take;
    logic                        any, load_en;
    logic [AW-1:0]               sel_addr;

    mmu_pf_cfg #(.AW(AW), .NPL(NPL)) cfg_i (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .ctrl_word(ctrl_word), .base_flat(plane_base), .size_flat(plane_size),
        .mode(cfg_mode), .depth(cfg_depth), .shift(cfg_shift),
        .base(cfg_base), .size(cfg_size)
    );

    for (genvar p = 0; p < NPL; p++) begin : g_trk
        mmu_pf_plane #(.AW(AW)) plane_i (
            .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
            .mode(cfg_mode), .depth(cfg_depth), .shift(cfg_shift[p]),
            .base(cfg_base[p]), .size(cfg_size[p]),
            .read_valid(read_valid), .read_addr(read_addr),
            .take(take[p]), .want(want[p]), .page_addr(pg_addr[p])
        );
    end

    mmu_pf_pick #(.N(NPL)) pick_i (.want(want), .gnt(gnt), .any(any));

    // the slot can load when it is empty or is being drained
    always_comb begin
        load_en = !req_valid || req_ready;
        take    = (load_en && !frame_start) ? gnt : '0;
    end

    // mux the granted plane's page address
    always_comb begin
        sel_addr = '0;
        for (int p = 0; p < NPL; p++)
            if (gnt[p]) sel_addr = sel_addr | pg_addr[p];
    end

    // output register holding the offered request
    always_ff @(posedge clk) begin
        if (!rst_n || frame_start) begin
            req_valid <= 1'b0;
            req_addr  <= '0;
        end else if (load_en) begin
            req_valid <= any;
            if (any) req_addr <= sel_addr;
        end
    end

    // full mode is done when no plane wants more and the slot is empty
    always_comb full_done = (cfg_mode == PF_FULL) && !any && !req_valid;

endmodule

// File: rtl/mmu_prefetcher_chk.sv
// Protocol and mode checks for mmu_prefetcher, bound to every instance.
module mmu_prefetcher_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          frame_start,
    input logic          req_valid,
    input logic          req_ready,
    input logic [AW-1:0] req_addr,
    input logic          full_done,
    input logic [1:0]    cfg_mode
);

    AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready && !frame_start) |=> (req_valid && $stable(req_addr))); // R11

    AST_PAGE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_addr[11:0] == 12'h000)); // R7

    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'd0) |-> (!req_valid && !full_done)); // R1

    AST_FRAME_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !req_valid); // R8

    AST_DONE_FULL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        full_done |-> (cfg_mode == 2'd2 && !req_valid)); // R9

endmodule

bind mmu_prefetcher mmu_prefetcher_chk #(.AW(AW)) chk_i (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .full_done(full_done), .cfg_mode(cfg_mode)
);

// File: tb/mmu_prefetcher_tb_top.sv
// Sweep bench for mmu_prefetcher with three 32-bit planes.
module mmu_prefetcher_tb_top;

    localparam int  CLK_PERIOD = 10;
    localparam int  AW  = 32;
    localparam int  NPL = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              frame_start = 1'b0;
    logic [31:0]       ctrl_word = '0;
    logic [NPL*AW-1:0] plane_base = '0;
    logic [NPL*AW-1:0] plane_size = '0;
    logic              read_valid = 1'b0;
    logic [AW-1:0]     read_addr = '0;
    logic              req_valid;
    logic              req_ready = 1'b0;
    logic [AW-1:0]     req_addr;
    logic              full_done;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic [31:0] got  [0:511];
    logic [31:0] expv [0:511];
    int n_got, n_exp;

    always #(CLK_PERIOD/2) clk = ~clk;

    mmu_prefetcher #(.AW(AW), .NPL(NPL)) dut_i (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .ctrl_word(ctrl_word), .plane_base(plane_base), .plane_size(plane_size),
        .read_valid(read_valid), .read_addr(read_addr),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .full_done(full_done)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_ctrl(bit en, bit partial, logic [2:0] big, logic [6:0] depth);
        return {13'b0, depth, 1'b0, big, 3'b0, partial, 3'b0, en};
    endfunction

    task automatic set_planes(input logic [31:0] b0, s0, b1, s1, b2, s2);
        plane_base = {b2, b1, b0};
        plane_size = {s2, s1, s0};
    endtask

    task automatic start_frame(input logic [31:0] ctrl);
        @(negedge clk);
        ctrl_word   = ctrl;
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        n_got = 0;
    endtask

    // collect accepted requests for ncyc cycles; bp adds ready stalls
    task automatic collect(input int ncyc, input bit bp);
        for (int c = 0; c < ncyc; c++) begin
            @(negedge clk);
            req_ready = bp ? ((c % 3) != 2) : 1'b1;
            if (req_valid && req_ready) begin
                if (n_got < 512) got[n_got] = req_addr;
                n_got++;
            end
        end
        @(negedge clk);
        req_ready = 1'b0;
    endtask

    // expected list from the programmed planes, computed arithmetically
    task automatic build_exp(input bit full, input int depth, input logic [2:0] big);
        n_exp = 0;
        for (int p = 0; p < NPL; p++) begin
            logic [31:0] b, s, first, np, cnt;
            int sh;
            b  = plane_base[p*AW +: AW];
            s  = plane_size[p*AW +: AW];
            sh = full ? (big[p] ? 21 : 20) : (big[p] ? 16 : 12);
            first = b >> sh;
            np = (s == 0) ? 0 : (((b + s - 1) >> sh) - first + 1);
            cnt = full ? np : ((np < depth) ? np : depth);
            for (int i = 0; i < cnt; i++) begin
                expv[n_exp] = (first + i) << sh;
                n_exp++;
            end
        end
    endtask

    task automatic compare_lists(input string req);
        check(n_got == n_exp, {req, " count"}, n_got, n_exp);
        for (int i = 0; i < n_exp && i < n_got; i++)
            check(got[i] == expv[i], {req, " addr"}, got[i], expv[i]);
    endtask

    task automatic read_at(input logic [31:0] a);
        @(negedge clk);
        read_valid = 1'b1;
        read_addr  = a;
        @(negedge clk);
        read_valid = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        check(req_valid == 1'b0, "R12 req_valid", req_valid, 0);
        check(full_done == 1'b0, "R12 full_done", full_done, 0);

        // R1: disabled with mode bit and depth set
        set_planes(32'h0010_0000, 32'h6000, 32'h0100_0800, 32'h9_0000, 32'h0200_0000, 32'h2001);
        start_frame(mk_ctrl(1'b0, 1'b1, 3'b111, 7'd8));
        collect(60, 1'b0);
        check(n_got == 0, "R1 no requests when off", n_got, 0);
        check(full_done == 1'b0, "R1 done low when off", full_done, 0);

        // R2 R4 R6 R7 R9: full mode over all page-size patterns, unaligned bases
        set_planes(32'h0030_0000, 32'h0030_0000, 32'h1000_0000, 32'h0010_0001,
                   32'h2010_0000, 32'h0050_0000);
        for (int big = 0; big < 8; big++) begin
            start_frame(mk_ctrl(1'b1, 1'b0, big[2:0], 7'd8));
            check(full_done == 1'b0, "R9 done low at frame begin", full_done, 0);
            collect(60, big[0]);
            build_exp(1'b1, 0, big[2:0]);
            compare_lists("R6 full sweep");
            check(full_done == 1'b1, "R9 done after last page", full_done, 1);
        end

        // R3 R4 R7: partial depth sweep with no reader activity
        set_planes(32'h0010_0000, 32'h6000, 32'h0100_0800, 32'h9_0000, 32'h0200_0000, 32'h2001);
        for (int di = 0; di < 5; di++) begin
            int d;
            d = (di == 0) ? 0 : (di == 1) ? 1 : (di == 2) ? 2 : (di == 3) ? 5 : 127;
            for (int big = 0; big < 8; big++) begin
                start_frame(mk_ctrl(1'b1, 1'b1, big[2:0], d[6:0]));
                collect(330, big[1]);
                build_exp(1'b0, d, big[2:0]);
                compare_lists("R3 partial depth");
                check(full_done == 1'b0, "R9 done low in partial", full_done, 0);
            end
        end

        // R5 R10: reader tracking on a 20-page plane with depth 4
        set_planes(32'h0040_0000, 32'h0001_4000, 32'h0, 32'h0, 32'h0, 32'h0);
        start_frame(mk_ctrl(1'b1, 1'b1, 3'b000, 7'd4));
        collect(20, 1'b0);
        check(n_got == 4, "R5 initial window", n_got, 4);
        read_at(32'h0040_0010);
        collect(20, 1'b0);
        check(n_got == 5, "R5 after page 0", n_got, 5);
        read_at(32'h0040_3ff0);
        collect(20, 1'b0);
        check(n_got == 8, "R5 after page 3", n_got, 8);
        read_at(32'h0040_1000);
        collect(20, 1'b0);
        check(n_got == 8, "R5 backward read no growth", n_got, 8);
        read_at(32'h0040_a000);
        collect(20, 1'b0);
        check(n_got == 15, "R5 after page 10", n_got, 15);
        read_at(32'h0041_3fff);
        collect(30, 1'b0);
        check(n_got == 20, "R10 clamp at end", n_got, 20);
        n_exp = 20;
        for (int i = 0; i < 20; i++) expv[i] = 32'h0040_0000 + i * 32'h1000;
        compare_lists("R7 R10 tracked list");

        // R8: restart while a request is held under stall
        set_planes(32'h0050_0000, 32'h8000, 32'h0, 32'h0, 32'h0, 32'h0);
        start_frame(mk_ctrl(1'b1, 1'b1, 3'b000, 7'd2));
        repeat (3) @(negedge clk);
        check(req_valid && req_addr == 32'h0050_0000, "R11 held offer", req_addr, 32'h0050_0000);
        set_planes(32'h0070_0800, 32'h8000, 32'h0, 32'h0, 32'h0, 32'h0);
        start_frame(mk_ctrl(1'b1, 1'b1, 3'b000, 7'd2));
        collect(20, 1'b0);
        n_exp = 2;
        expv[0] = 32'h0070_0000;
        expv[1] = 32'h0070_1000;
        compare_lists("R8 restart");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule